// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between a clocked host and an external asynchronous static RAM with a 19-bit address, an 8-bit bidirectional data bus and three active-low strobes (select, output enable, write enable). The host offers one byte-wide read or write at a time over a request/ready handshake. The controller registers the address and write data when it accepts the request. It then drives the strobes for a fixed number of clock cycles and returns ready, together with the read data for a read.

The strobe widths are not hand-tuned. Each one is derived at elaboration from nanosecond minimums and the clock period. Each count is the ceiling of the time divided by the period, with a floor of one cycle. A read keeps select and output enable low for the longer of the cycle-time and access-time counts. A write pulses write enable low for the largest of these counts: the pulse width, the address-to-end-of-write time, the select-to-end-of-write time, the data setup time, and the write-cycle time less one cycle. Output enable stays high throughout a write. The controller keeps driving the data bus for one cycle after write enable rises, so the data hold time is met, and it never drives the bus while output enable is low.

Top module: `sramc_top`

## Requirements
- R1: While reset is high and in the cycle after it, select, output enable and write enable are all high, the data bus is not driven and ready is high.
- R2: A read (write flag 0) holds select and output enable low with write enable high for RD_CYC cycles. The byte present on the bus in the last of those cycles is returned on the read data output.
- R3: A write (write flag 1) holds select and write enable low for WR_CYC cycles with output enable high throughout. The RAM sees address and data stable for at least 13 ns and at least 8 ns respectively before write enable rises, and a write-enable pulse of at least 13 ns.
- R4: Each cycle count is max(1, ceil(t_ps / CLK_PS)). With the default 5 ns clock, RD_CYC = 3 and WR_CYC = 3.
- R5: The data bus is driven only while write enable is low and for the one cycle after it rises, and never while output enable is low.
- R6: Address and write data seen by the RAM are the values taken at acceptance and stay constant for the whole access, even if the host inputs change.
- R7: Ready falls on the clock that accepts a request and rises one clock after the strobes return high, so an access takes strobe count + 1 cycles from acceptance to ready.
- R8: A request presented while ready is low is ignored. It causes no RAM access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request; accepted on a clock where ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_rdy | output | 1 | High when idle; rises with valid read data |
| host_rdata | output | DATA_W | Data returned by the last read |
| ram_addr | output | ADDR_W | RAM address bus |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq | inout | DATA_W | RAM bidirectional data bus |

## Verification
Several properties are checked on every clock. These are: no overlap between the controller's bus driver and an active output enable; output enable held high during write pulses; the address held steady while selected; the exact strobe widths in cycles; and ready rising one clock after select rises. What only the bench scenarios can show is data correctness. The RAM model built into the bench returns a wrong pattern until the access time has elapsed. It also times setup and pulse widths in nanoseconds, so reads must land late enough and writes must store the right byte at the right address. The bench also shows that host inputs changed or re-requested while busy leave the RAM untouched.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } sramc_state_e;

  // ceiling of a time over the clock period, never below one cycle
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq #(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic req_we,
  output logic rdy,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic drv_en,
  output logic load,
  output logic capture
);
  import sramc_pkg::*;

  localparam int unsigned MAXC  = umax(RD_CYC, WR_CYC);
  localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  sramc_state_e     state;
  logic [CNT_W-1:0] cnt;

  assign load    = (state == ST_IDLE) && req;
  assign capture = (state == ST_READ) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cs_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      drv_en <= 1'b0;
      rdy    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req) begin
            rdy  <= 1'b0;
            cs_n <= 1'b0;
            if (req_we) begin
              we_n   <= 1'b0;
              drv_en <= 1'b1;
              cnt    <= CNT_W'(WR_CYC - 1);
              state  <= ST_WRITE;
            end else begin
              oe_n  <= 1'b0;
              cnt   <= CNT_W'(RD_CYC - 1);
              state <= ST_READ;
            end
          end
        end
        ST_READ, ST_WRITE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          drv_en <= 1'b0;
          rdy    <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q  <= in_addr;
        wdata_q <= in_wdata;
      end
      if (capture) rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_RC_PS   = 15000,
  parameter int unsigned T_AA_PS   = 15000,
  parameter int unsigned T_WP_PS   = 13000,
  parameter int unsigned T_AW_PS   = 13000,
  parameter int unsigned T_CW_PS   = 13000,
  parameter int unsigned T_DW_PS   = 8000,
  parameter int unsigned T_WC_PS   = 15000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rdy,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  inout  wire  [DATA_W-1:0] ram_dq
);
  import sramc_pkg::*;

  localparam int unsigned RD_CYC = umax(ps_to_cyc(T_RC_PS, CLK_PS), ps_to_cyc(T_AA_PS, CLK_PS));
  localparam int unsigned WR_CYC = umax(umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_AW_PS, CLK_PS)),
                                        umax(umax(ps_to_cyc(T_CW_PS, CLK_PS), ps_to_cyc(T_DW_PS, CLK_PS)),
                                             ps_to_cyc(T_WC_PS, CLK_PS) - 1));

  logic              dq_oe;
  logic              load;
  logic              capture;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] dq_in;

  sramc_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .req     (host_req),
    .req_we  (host_we),
    .rdy     (host_rdy),
    .cs_n    (ram_cs_n),
    .oe_n    (ram_oe_n),
    .we_n    (ram_we_n),
    .drv_en  (dq_oe),
    .load    (load),
    .capture (capture)
  );

  sramc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .capture  (capture),
    .in_addr  (host_addr),
    .in_wdata (host_wdata),
    .bus_in   (dq_in),
    .addr_q   (ram_addr),
    .wdata_q  (wdata_q),
    .rdata_q  (host_rdata)
  );

  assign ram_dq = dq_oe ? wdata_q : 'z;
  assign dq_in  = ram_dq;

endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rdy,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              dq_oe
);

  logic [15:0] we_lo;
  logic [15:0] oe_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo <= '0;
      oe_lo <= '0;
    end else begin
      we_lo <= ram_we_n ? 16'd0 : we_lo + 16'd1;
      oe_lo <= ram_oe_n ? 16'd0 : oe_lo + 16'd1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (ram_cs_n && ram_oe_n && ram_we_n && !dq_oe && host_rdy));

  a_r2_read_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_oe_n) |-> (oe_lo == 16'(RD_CYC)));

  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (ram_oe_n && !ram_cs_n));

  a_r4_write_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (we_lo == 16'(WR_CYC)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !ram_oe_n));

  a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> dq_oe);

  a_r5_drive_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> dq_oe ##1 !dq_oe);

  a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

  a_r7_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
    !ram_cs_n |-> !host_rdy);

  a_r7_ready_after_strobes: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_cs_n) |=> host_rdy);

endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .host_rdy (host_rdy),
  .ram_addr (ram_addr),
  .ram_cs_n (ram_cs_n),
  .ram_oe_n (ram_oe_n),
  .ram_we_n (ram_we_n),
  .dq_oe    (dq_oe)
);

// File: tb/sramc_top_tb_top.sv
`timescale 1ns/1ps
module sramc_top_tb_top;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int NV = 9;

  // requirement R4: ceiling of ns over the 5 ns period, at least one
  function automatic int cyc(input int t_ns);
    int n;
    n = (t_ns + 4) / 5;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP = imax(cyc(15), cyc(15));
  localparam int WR_EXP = imax(imax(cyc(13), cyc(8)), cyc(15) - 1);

  // {write flag, address, data (write data or expected read data)}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 19'h00000, 8'hA5},
    {1'b1, 19'h7FFFF, 8'h3C},
    {1'b1, 19'h12345, 8'h5A},
    {1'b0, 19'h00000, 8'hA5},
    {1'b0, 19'h7FFFF, 8'h3C},
    {1'b0, 19'h12345, 8'h5A},
    {1'b1, 19'h12345, 8'hC3},
    {1'b0, 19'h12345, 8'hC3},
    {1'b0, 19'h00001, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rdy;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_cs_n, ram_oe_n, ram_we_n;
  wire  [DW-1:0] ram_dq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sramc_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .host_req   (req),
    .host_we    (req_we),
    .host_addr  (req_addr),
    .host_wdata (req_wdata),
    .host_rdy   (rdy),
    .host_rdata (rdata),
    .ram_addr   (ram_addr),
    .ram_cs_n   (ram_cs_n),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n),
    .ram_dq     (ram_dq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic          rd_ok = 1'b0;
  logic [DW-1:0] model_q = '0;
  logic          armed = 1'b0;
  realtime       t_wf = 0.0, t_dq = 0.0, t_ad = 0.0;
  int            wr_count = 0;

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  assign ram_dq = (!ram_cs_n && !ram_oe_n && ram_we_n) ? (rd_ok ? model_q : 8'hEE) : 'z;

  // data appears 14 ns after output enable falls; wrong pattern before that
  always begin
    @(negedge ram_oe_n);
    rd_ok = 1'b0;
    repeat (14) #1;
    if (!ram_oe_n) begin
      model_q = peek(ram_addr);
      rd_ok   = 1'b1;
      @(posedge ram_oe_n);
      rd_ok = 1'b0;
    end
  end

  always @(ram_dq)   t_dq = $realtime;
  always @(ram_addr) t_ad = $realtime;
  always @(negedge ram_we_n) begin
    t_wf  = $realtime;
    armed = 1'b1;
  end
  always @(posedge ram_we_n) begin
    if (armed) begin
      armed = 1'b0;
      check("R3 write pulse >= 13ns", int'($realtime - t_wf >= 13.0), 1);
      check("R3 data setup >= 8ns",   int'($realtime - t_dq >= 8.0), 1);
      check("R3 addr setup >= 13ns",  int'($realtime - t_ad >= 13.0), 1);
      check("R3 output enable high",  int'(ram_oe_n), 1);
      mem[ram_addr] = ram_dq;
      wr_count++;
    end
  end

  // ---------------- host side ----------------
  task automatic run_req(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic poke, output logic [DW-1:0] q, output int lat, output int strobe);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    lat = 0; strobe = 0;
    if (poke) begin
      req_we = 1'b1; req_addr = 19'h00055; req_wdata = 8'h99;
    end else begin
      req = 1'b0;
    end
    while (!rdy && lat < 64) begin
      lat++;
      if (!ram_cs_n) strobe++;
      @(negedge clk);
    end
    req = 1'b0;
    q = rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    int lat, strobe, wc0;

    repeat (3) @(negedge clk);
    check("R1 select high in reset", int'(ram_cs_n), 1);
    check("R1 write enable high in reset", int'(ram_we_n), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 select high", int'(ram_cs_n), 1);
    check("R1 output enable high", int'(ram_oe_n), 1);
    check("R1 write enable high", int'(ram_we_n), 1);
    check("R1 ready high", int'(rdy), 1);

    for (int i = 0; i < NV; i++) begin
      logic          we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {we, a, d} = VEC[i];
      run_req(we, a, d, 1'b0, q, lat, strobe);
      if (we) begin
        check("R3 stored byte", int'(peek(a)), int'(d));
        check("R4 write strobe cycles", strobe, WR_EXP);
        check("R7 write latency", lat, WR_EXP + 1);
      end else begin
        check("R2 R5 read data", int'(q), int'(d));
        check("R4 read strobe cycles", strobe, RD_EXP);
        check("R7 read latency", lat, RD_EXP + 1);
      end
    end

    // host inputs change and re-request while busy
    wc0 = wr_count;
    run_req(1'b1, 19'h00200, 8'h6B, 1'b1, q, lat, strobe);
    repeat (3) @(negedge clk);
    check("R8 single access while busy", wr_count - wc0, 1);
    run_req(1'b0, 19'h00200, 8'h00, 1'b0, q, lat, strobe);
    check("R6 held address and data", int'(q), 8'h6B);
    run_req(1'b0, 19'h00055, 8'h00, 1'b0, q, lat, strobe);
    check("R8 busy request not written", int'(q), 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule